// File: doc/BRIEF.md
# Down-Counting Interval Timer with Watchdog Mode

The block is a single 32-bit down counter, paced by an 8-bit clock divider, that software drives through six word registers. In timer mode, whenever the count steps down to zero, the block sets a sticky event bit. That bit drives an interrupt line when software has enabled it. The counter can then refill itself from a reload value to produce a periodic tick, or it can stay at zero and act as a one-shot.

Software can switch the same counter into watchdog mode. In that mode, reaching zero produces a single-cycle reset request and sets a sticky reset-cause bit. Software keeps the watchdog from expiring by rewriting the counter register, which refills it from the reload value. A plain control write cannot turn watchdog mode off. The only way out is two consecutive writes to a dedicated disarm register: first one fixed key word, then a second one.

Top module: `tick_guard_timer`

## Requirements
- R1: After reset, every register reads zero and both `irq_o` and `wd_reset_o` are low.
- R2: Byte offsets are: reload value 0x00, live count 0x04, control 0x08, event status 0x0C, reset-cause status 0x10, disarm 0x14. The disarm register and unmapped offsets read zero. Control fields are: bit 0 run, bit 1 auto-refill, bit 2 interrupt enable, bit 3 watchdog mode, bits 15:8 divider value. All other control bits read zero.
- R3: While run is set, the count drops by one every divider+1 clock cycles. While run is clear, the count holds. A write to the reload register copies the value into the count and restarts the divider. With reload L and divider P, zero is reached L*(P+1) cycles after the reload write.
- R4: In timer mode with auto-refill set, a step taken at zero refills the count from the reload value. Successive zero events are therefore (L+1)*(P+1) cycles apart.
- R5: Without auto-refill, the count stays at zero and raises no further events.
- R6: Event status bit 0 is set when the count reaches zero in timer mode. Writing 1 clears it and writing 0 leaves it unchanged. If a clear and a new event fall in the same cycle, the bit ends set.
- R7: `irq_o` is high exactly when event status bit 0 and the interrupt-enable bit are both set.
- R8: In watchdog mode, reaching zero gives one single-cycle pulse on `wd_reset_o` and sets reset-cause bit 0 (write 1 to clear, write 0 has no effect). Event status is not set, and the count stays at zero even when auto-refill is set.
- R9: A control write can set the watchdog bit but cannot clear it.
- R10: Watchdog mode ends only when 0x12345678 is written to the disarm register and the very next write is 0x87654321 to the disarm register. Any other write in between, or a wrong second word, cancels the first step. Writing 0x12345678 again restarts the first step.
- R11: A write to the count register in watchdog mode refills the count from the reload value and ignores the written data. In timer mode the written data becomes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 5 | Register byte offset for reads and writes |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Timer interrupt request |
| wd_reset_o | output | 1 | Watchdog reset request pulse |

## Verification
Two things can land on the same clock edge: the count stepping from one to zero, which sets the event bit, and a software write of 1 that clears that bit. The bench loads a small count with the divider at one cycle per step. It then times the clear write so that it lands exactly on the edge where the count reaches zero, and expects the bit to read back as set. A second collision, between a count-register write and a divider step, is covered by the watchdog service test: after the write, the count reads as the reload value and not one less.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 32;
    localparam int PRE_W  = 8;
    localparam int ADDR_W = 5;

    localparam int PRE_LSB = 8;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CAUSE  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_DISARM = 5'h14;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h1234_5678;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h8765_4321;

    typedef struct packed {
        logic [PRE_W-1:0] div;
        logic             guard;
        logic             irq_en;
        logic             refill;
        logic             run;
    } ctrl_t;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_HALF = 1'b1
    } arm_e;

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PRE_LSB +: PRE_W] = c.div;
        w[3] = c.guard;
        w[2] = c.irq_en;
        w[1] = c.refill;
        w[0] = c.run;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w, input logic keep_guard);
        ctrl_t c;
        c.div    = w[PRE_LSB +: PRE_W];
        c.guard  = keep_guard | w[3];
        c.irq_en = w[2];
        c.refill = w[1];
        c.run    = w[0];
        return c;
    endfunction

endpackage

// File: rtl/tgt_prescaler.sv
module tgt_prescaler #(
    parameter int PRE_W = tgt_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] limit_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] phase_q;
    logic             at_end;

    assign at_end = (phase_q >= limit_i);
    assign tick_o = run_i && !restart_i && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run_i || restart_i) begin
            phase_q <= '0;
        end else if (at_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (run_i && restart_i) |=> !at_end || limit_i == '0); // R3

endmodule

// File: rtl/tgt_counter.sv
module tgt_counter #(
    parameter int CNT_W = tgt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             reload_en_i,
    input  logic [CNT_W-1:0] reload_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign hit_o   = tick_i && !ld_i && (cnt_q == ONE);
    assign count_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (tick_i) begin
            if (!at_zero) begin
                cnt_q <= cnt_q - ONE;
            end else if (reload_en_i) begin
                cnt_q <= reload_val_i;
            end
        end
    end

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !ld_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !ld_i) |=> $stable(cnt_q)); // R3

    AST_ZERO_STOP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !ld_i && cnt_q == '0 && !reload_en_i) |=> cnt_q == '0); // R5

endmodule

// File: rtl/tgt_disarm.sv
module tgt_disarm #(
    parameter int DATA_W = tgt_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_any_i,
    input  logic              wr_dis_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              done_o
);
    import tgt_pkg::*;

    arm_e state_q;
    logic first_ok;

    assign first_ok = wr_dis_i && (data_i == KEY_FIRST);
    assign done_o   = wr_dis_i && (state_q == ARM_HALF) && (data_i == KEY_SECOND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARM_IDLE;
        end else if (wr_any_i) begin
            state_q <= first_ok ? ARM_HALF : ARM_IDLE;
        end
    end

    AST_HALF_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        (wr_any_i && !first_ok) |=> !done_o || !wr_dis_i || state_q == ARM_IDLE); // R10

endmodule

// File: rtl/tick_guard_timer.sv
module tick_guard_timer #(
    parameter int DATA_W = tgt_pkg::DATA_W,
    parameter int CNT_W  = tgt_pkg::CNT_W,
    parameter int PRE_W  = tgt_pkg::PRE_W,
    parameter int ADDR_W = tgt_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic              wd_reset_o
);
    import tgt_pkg::*;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic             event_q;
    logic             cause_q;
    logic             pulse_q;

    logic             wr_reload, wr_count, wr_ctrl, wr_event, wr_cause, wr_dis;
    logic             tick, hit, arm_done;
    logic             cnt_ld;
    logic [CNT_W-1:0] cnt_ld_val;
    logic [CNT_W-1:0] count;

    // Write decode
    assign wr_reload = wr_en_i && (addr_i == OFS_RELOAD);
    assign wr_count  = wr_en_i && (addr_i == OFS_COUNT);
    assign wr_ctrl   = wr_en_i && (addr_i == OFS_CTRL);
    assign wr_event  = wr_en_i && (addr_i == OFS_EVENT);
    assign wr_cause  = wr_en_i && (addr_i == OFS_CAUSE);
    assign wr_dis    = wr_en_i && (addr_i == OFS_DISARM);

    // Counter load source: watchdog service refills from the reload value
    assign cnt_ld     = wr_reload || wr_count;
    assign cnt_ld_val = (wr_count && ctrl_q.guard) ? reload_q : wr_data_i[CNT_W-1:0];

    tgt_prescaler #(.PRE_W(PRE_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run_i     (ctrl_q.run),
        .restart_i (cnt_ld),
        .limit_i   (ctrl_q.div),
        .tick_o    (tick)
    );

    tgt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .ld_i         (cnt_ld),
        .ld_val_i     (cnt_ld_val),
        .reload_en_i  (ctrl_q.refill && !ctrl_q.guard),
        .reload_val_i (reload_q),
        .count_o      (count),
        .hit_o        (hit)
    );

    tgt_disarm #(.DATA_W(DATA_W)) u_arm (
        .clk      (clk),
        .rst      (rst),
        .wr_any_i (wr_en_i),
        .wr_dis_i (wr_dis),
        .data_i   (wr_data_i),
        .done_o   (arm_done)
    );

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= word_to_ctrl(wr_data_i, ctrl_q.guard);
            end else if (arm_done) begin
                ctrl_q.guard <= 1'b0;
            end
            if (wr_reload) begin
                reload_q <= wr_data_i[CNT_W-1:0];
            end
        end
    end

    // Sticky flags: a new event beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            event_q <= 1'b0;
            cause_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (hit && !ctrl_q.guard) begin
                event_q <= 1'b1;
            end else if (wr_event && wr_data_i[0]) begin
                event_q <= 1'b0;
            end
            if (hit && ctrl_q.guard) begin
                cause_q <= 1'b1;
            end else if (wr_cause && wr_data_i[0]) begin
                cause_q <= 1'b0;
            end
            pulse_q <= hit && ctrl_q.guard;
        end
    end

    assign irq_o      = event_q && ctrl_q.irq_en;
    assign wd_reset_o = pulse_q;

    // Read mux
    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            OFS_RELOAD: rd_data_o = DATA_W'(reload_q);
            OFS_COUNT:  rd_data_o = DATA_W'(count);
            OFS_CTRL:   rd_data_o = ctrl_to_word(ctrl_q);
            OFS_EVENT:  rd_data_o = DATA_W'(event_q);
            OFS_CAUSE:  rd_data_o = DATA_W'(cause_q);
            default:    rd_data_o = '0;
        endcase
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wd_reset_o |=> !wd_reset_o); // R8

    AST_CAUSE_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_q) |-> wd_reset_o); // R8

    AST_EVENT_TIMER_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(event_q) |-> !$past(ctrl_q.guard)); // R6

    AST_GUARD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.guard && !arm_done) |=> ctrl_q.guard); // R9

    AST_GUARD_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.guard) |-> $past(arm_done)); // R10

endmodule

// File: tb/tick_guard_timer_bench.sv
`timescale 1ns/1ps
module tick_guard_timer_bench;

    localparam logic [4:0] A_RELOAD = 5'h00;
    localparam logic [4:0] A_COUNT  = 5'h04;
    localparam logic [4:0] A_CTRL   = 5'h08;
    localparam logic [4:0] A_EVENT  = 5'h0C;
    localparam logic [4:0] A_CAUSE  = 5'h10;
    localparam logic [4:0] A_DIS    = 5'h14;

    // {divider, reload} pairs for the periodic walk
    localparam logic [15:0] VEC [5] = '{16'h0003, 16'h0102, 16'h0204, 16'h0001, 16'h0305};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic        wen = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        wdr;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit finished = 0;

    tick_guard_timer u_tick_guard_timer (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr),
        .wr_en_i    (wen),
        .wr_data_i  (wdata),
        .rd_data_o  (rdata),
        .irq_o      (irq),
        .wd_reset_o (wdr)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (!rst && wdr) pulses++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; wen = 1'b1;
        @(posedge clk); #1;
        wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a; #1;
        d = rdata;
    endtask

    // Counts edges until the selected signal is seen high
    task automatic measure(input bit sel_wd, input int k0, output int k);
        k = k0;
        if (!sel_wd) addr = A_EVENT;
        while (1) begin
            @(posedge clk); k++; #2;
            if (sel_wd ? wdr : rdata[0]) break;
            if (k > 3000) break;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int k;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(5'(a * 4), d); chk("R1 reset reg", d, 0);
        end
        chk("R1 irq low", irq, 0);
        chk("R1 wd_reset low", wdr, 0);

        // R4 / R3 / R7 periodic walk over the table
        for (int i = 0; i < 5; i++) begin
            int p, l;
            p = VEC[i][15:8]; l = VEC[i][7:0];
            wr(A_CTRL, {16'h0, 8'(p), 8'h07});
            wr(A_RELOAD, 32'(l));
            measure(0, 0, k); chk("R3 first zero delay", k, l * (p + 1));
            chk("R7 irq with enable", irq, 1);
            wr(A_EVENT, 1);
            measure(0, 1, k); chk("R4 refill period", k, (l + 1) * (p + 1));
            wr(A_CTRL, 0); wr(A_EVENT, 1);
        end

        // R2 map and field readback
        wr(A_CTRL, 32'hFFFF_FFF7);
        rd(A_CTRL, d); chk("R2 control fields", d, 32'h0000_FF07);
        wr(A_CTRL, 0);
        rd(A_DIS, d); chk("R2 disarm reads zero", d, 0);
        rd(5'h18, d); chk("R2 unmapped reads zero", d, 0);

        // R3 hold while stopped
        wr(A_RELOAD, 50);
        repeat (10) @(posedge clk); #1;
        rd(A_COUNT, d); chk("R3 hold when stopped", d, 50);
        rd(A_RELOAD, d); chk("R2 reload readback", d, 50);
        // R11 timer-mode count write
        wr(A_COUNT, 9);
        rd(A_COUNT, d); chk("R11 timer count write", d, 9);

        // R5 one-shot
        wr(A_EVENT, 1);
        wr(A_CTRL, 32'h0000_0101);
        wr(A_RELOAD, 3);
        repeat (20) @(posedge clk); #1;
        rd(A_COUNT, d); chk("R5 one-shot stays zero", d, 0);
        rd(A_EVENT, d); chk("R5 one-shot event", d, 1);
        wr(A_EVENT, 1);
        repeat (20) @(posedge clk); #1;
        rd(A_EVENT, d); chk("R5 no second event", d, 0);

        // R6 event and clear on the same edge
        wr(A_CTRL, 0); wr(A_EVENT, 1);
        wr(A_RELOAD, 3);
        wr(A_CTRL, 1);
        repeat (2) @(posedge clk); #1;
        wr(A_EVENT, 1);
        rd(A_EVENT, d); chk("R6 set beats clear", d, 1);
        chk("R7 irq masked", irq, 0);
        wr(A_CTRL, 5);
        chk("R7 irq unmasked", irq, 1);
        wr(A_EVENT, 0);
        rd(A_EVENT, d); chk("R6 write zero keeps", d, 1);
        wr(A_EVENT, 1);
        rd(A_EVENT, d); chk("R6 write one clears", d, 0);

        // R8 watchdog expiry
        wr(A_CTRL, 0); wr(A_CAUSE, 1);
        wr(A_RELOAD, 4);
        pulses = 0;
        wr(A_CTRL, 32'h0000_000B);
        measure(1, 0, k); chk("R8 expiry delay", k, 4);
        @(posedge clk); #2;
        chk("R8 pulse one cycle", wdr, 0);
        repeat (6) @(posedge clk); #1;
        chk("R8 single pulse", pulses, 1);
        rd(A_COUNT, d); chk("R8 count stays zero", d, 0);
        rd(A_CAUSE, d); chk("R8 cause set", d, 1);
        rd(A_EVENT, d); chk("R8 no timer event", d, 0);

        // R11 service
        wr(A_RELOAD, 100);
        repeat (10) @(posedge clk); #1;
        wr(A_COUNT, 7);
        rd(A_COUNT, d); chk("R11 service refills", d, 100);

        // R9 guard cannot be written off
        wr(A_CTRL, 0);
        rd(A_CTRL, d); chk("R9 guard sticky", d, 8);

        // R10 disarm sequences
        wr(A_DIS, 32'h1234_5678); wr(A_RELOAD, 5); wr(A_DIS, 32'h8765_4321);
        rd(A_CTRL, d); chk("R10 interrupted sequence", d, 8);
        wr(A_DIS, 32'h1234_5678); wr(A_DIS, 32'hDEAD_BEEF); wr(A_DIS, 32'h8765_4321);
        rd(A_CTRL, d); chk("R10 wrong word", d, 8);
        wr(A_DIS, 32'h8765_4321); wr(A_DIS, 32'h1234_5678);
        rd(A_CTRL, d); chk("R10 reverse order", d, 8);
        wr(A_DIS, 32'h1234_5678); wr(A_DIS, 32'h8765_4321);
        rd(A_CTRL, d); chk("R10 proper sequence", d, 0);

        // R8 cause flag clear
        wr(A_CAUSE, 0);
        rd(A_CAUSE, d); chk("R8 cause write zero keeps", d, 1);
        wr(A_CAUSE, 1);
        rd(A_CAUSE, d); chk("R8 cause write one clears", d, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule